// File: doc/BRIEF.md
# Machine Status Word Update Unit

This unit holds the processor's machine status word and applies the changes that happen without any software write. A few of its bits follow the instruction stream: each retiring instruction clears the data-break-disable bit, records whether it was a taken branch, and can arm the nullify bit for the instruction after it. Another bit records whether the last interruption was a high-priority machine check. A return-from-interruption reloads the whole word from a restored copy. Software can overwrite the word at any time through a write port.

The unit also runs a recovery counter. While the counter-enable bit of the word is set, the counter counts down once for each instruction that really executes, and it raises a trap request whenever its lowest bit is 1. Two pending-interrupt inputs pass to the outputs only when their unmask bits in the word are set. The pipeline drives the retire and interruption strobes. It reads the current word, the nullify-current signal, the trap request and the gated interrupts back from this unit.

Top module: `stw_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the word is all zeros and the recovery counter is zero. This leaves interrupts masked, translation off, and rc_trap, ext_take and pmu_take low. Asserting rst_n low clears the state at once, without waiting for a clock edge.
- R2: The bit field uses these positions: bit 0 external unmask, bit 1 data translation, bit 2 code translation, bit 3 perf-monitor unmask, bit 4 counter enable, bit 5 nullify, bit 6 data-break disable, bit 7 taken branch, bit 8 machine-check mask. An executed return-from-interruption (ret_rfi) loads ret_word into the word with bit 7 forced to 0. Any other executed retire clears bit 6.
- R3: An executed retire that is not a return-from-interruption sets bit 7 to ret_taken. A nullified retire clears bit 7.
- R4: nullify_cur equals bit 5. An executed retire sets bit 5 to ret_nullnext. A retire that arrives while bit 5 is 1 is nullified: it loads nothing, clears bits 5, 6 and 7, and does not step the counter.
- R5: On irq_vld, bit 8 takes the value of irq_hpmc. No other bit of the word changes.
- R6: When irq_vld and ret_vld are high in the same cycle, the retire is ignored: it neither updates the word nor steps the counter.
- R7: sw_we loads sw_word into the whole word. This write overrides every interruption update and retire update in the same cycle.
- R8: With bit 4 set, the counter decrements by one, wrapping modulo 2^32, on each executed retire that has no interruption and no software write in the same cycle. With bit 4 clear, the counter holds its value.
- R9: rc_trap is high exactly when bit 4 is 1 and bit 0 of the counter is 1.
- R10: ext_take equals ext_pend gated by bit 0 of the word. pmu_take equals pmu_pend gated by bit 3.
- R11: rc_we loads rc_wdata into the counter. This load takes priority over a decrement in the same cycle.
- R12: In a cycle with no strobe, the word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| ret_vld | input | 1 | An instruction retires this cycle |
| ret_taken | input | 1 | The retiring instruction is a taken branch |
| ret_nullnext | input | 1 | The retiring instruction nullifies its successor |
| ret_rfi | input | 1 | The retiring instruction is a return-from-interruption |
| ret_word | input | 32 | Restored word for a return-from-interruption |
| irq_vld | input | 1 | An interruption is taken this cycle |
| irq_hpmc | input | 1 | The interruption is a high-priority machine check |
| sw_we | input | 1 | Software write strobe for the word |
| sw_word | input | 32 | Software write data for the word |
| rc_we | input | 1 | Recovery counter load strobe |
| rc_wdata | input | 32 | Recovery counter load value |
| ext_pend | input | 1 | External interrupt pending |
| pmu_pend | input | 1 | Performance-monitor interrupt pending |
| status_word | output | 32 | Current status word |
| nullify_cur | output | 1 | The instruction now retiring is nullified |
| rc_value | output | 32 | Current recovery counter value |
| rc_trap | output | 1 | Recovery counter trap request |
| ext_take | output | 1 | External interrupt unmasked and pending |
| pmu_take | output | 1 | Perf-monitor interrupt unmasked and pending |

## Verification
The bench puts an interruption, a retire and a software write in the same cycle. A design with the wrong priority would let a taken-branch flag or a cleared mask bit leak through. It retires a taken branch, and then a return-from-interruption, while the nullify bit is armed. A design that ignored nullification would set the taken-branch bit, reload the word, or count down on an instruction that never ran. It also loads the counter in the same cycle as a retire, counts down through zero to check the wrap, and clears the counter-enable bit while the counter's lowest bit is 1. A design that got these wrong would show up as a stale counter value, or as a trap request raised while counting is disabled.

// File: rtl/stw_pkg.sv
package stw_pkg;

  // Bit positions inside the status word
  localparam int unsigned POS_EXT_UNMASK = 0;
  localparam int unsigned POS_DATA_XLAT  = 1;
  localparam int unsigned POS_CODE_XLAT  = 2;
  localparam int unsigned POS_PMU_UNMASK = 3;
  localparam int unsigned POS_RC_ENABLE  = 4;
  localparam int unsigned POS_NULLIFY    = 5;
  localparam int unsigned POS_BRK_DIS    = 6;
  localparam int unsigned POS_TAKEN      = 7;
  localparam int unsigned POS_MC_MASK    = 8;
  localparam int unsigned NUM_DEF_BITS   = 9;

  // Retire flags travelling as one bundle
  typedef struct packed {
    logic vld;
    logic taken;
    logic nullnext;
    logic rfi;
  } retire_t;

endpackage

// File: rtl/stw_rst_sync.sv
module stw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/stw_word_next.sv
module stw_word_next
  import stw_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [WORD_W-1:0] cur,
  input  retire_t           ret,
  input  logic [WORD_W-1:0] ret_word,
  input  logic              irq_vld,
  input  logic              irq_hpmc,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_word,
  output logic [WORD_W-1:0] nxt,
  output logic              exec_step
);

  logic killed;

  assign killed    = cur[POS_NULLIFY];
  assign exec_step = ret.vld & ~irq_vld & ~sw_we & ~killed;

  always_comb begin
    nxt = cur;
    if (sw_we) begin
      nxt = sw_word;
    end else if (irq_vld) begin
      nxt[POS_MC_MASK] = irq_hpmc;
    end else if (ret.vld) begin
      if (!killed && ret.rfi) begin
        nxt          = ret_word;
        nxt[POS_TAKEN] = 1'b0;
      end else begin
        nxt[POS_BRK_DIS] = 1'b0;
        nxt[POS_TAKEN]   = ret.taken & ~killed;
        nxt[POS_NULLIFY] = ret.nullnext & ~killed;
      end
    end
  end

endmodule

// File: rtl/stw_recovery_ctr.sv
module stw_recovery_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             step,
  input  logic             ld_en,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             trap
);

  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    cnt_en  = ld_en | (enable & step);
    cnt_nxt = ld_en ? ld_val : (cnt - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  assign trap = enable & cnt[0];

endmodule

// File: rtl/stw_irq_gate.sv
module stw_irq_gate #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] unmask,
  output logic [N_SRC-1:0] take
);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign take[g] = pend[g] & unmask[g];
  end

endmodule

// File: rtl/stw_unit.sv
module stw_unit
  import stw_pkg::*;
#(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned RST_SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_vld,
  input  logic              ret_taken,
  input  logic              ret_nullnext,
  input  logic              ret_rfi,
  input  logic [WORD_W-1:0] ret_word,
  input  logic              irq_vld,
  input  logic              irq_hpmc,
  input  logic              sw_we,
  input  logic [WORD_W-1:0] sw_word,
  input  logic              rc_we,
  input  logic [CNT_W-1:0]  rc_wdata,
  input  logic              ext_pend,
  input  logic              pmu_pend,
  output logic [WORD_W-1:0] status_word,
  output logic              nullify_cur,
  output logic [CNT_W-1:0]  rc_value,
  output logic              rc_trap,
  output logic              ext_take,
  output logic              pmu_take
);

  localparam int unsigned N_IRQ = 2;

  logic              rst_sync_n;
  retire_t           ret_bus;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_nxt;
  logic              word_en;
  logic              exec_step;
  logic [N_IRQ-1:0]  irq_take;

  stw_rst_sync #(.STAGES(RST_SYNC)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  assign ret_bus = '{vld: ret_vld, taken: ret_taken, nullnext: ret_nullnext, rfi: ret_rfi};

  stw_word_next #(.WORD_W(WORD_W)) u_word_next (
    .cur       (word_q),
    .ret       (ret_bus),
    .ret_word  (ret_word),
    .irq_vld   (irq_vld),
    .irq_hpmc  (irq_hpmc),
    .sw_we     (sw_we),
    .sw_word   (sw_word),
    .nxt       (word_nxt),
    .exec_step (exec_step)
  );

  assign word_en = sw_we | irq_vld | ret_vld;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  word_q <= '0;
    else if (word_en) word_q <= word_nxt;
  end

  stw_recovery_ctr #(.CNT_W(CNT_W)) u_rc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .enable (word_q[POS_RC_ENABLE]),
    .step   (exec_step),
    .ld_en  (rc_we),
    .ld_val (rc_wdata),
    .cnt    (rc_value),
    .trap   (rc_trap)
  );

  stw_irq_gate #(.N_SRC(N_IRQ)) u_gate (
    .pend   ({pmu_pend, ext_pend}),
    .unmask ({word_q[POS_PMU_UNMASK], word_q[POS_EXT_UNMASK]}),
    .take   (irq_take)
  );

  assign ext_take    = irq_take[0];
  assign pmu_take    = irq_take[1];
  assign status_word = word_q;
  assign nullify_cur = word_q[POS_NULLIFY];

endmodule

// File: rtl/stw_unit_chk.sv
module stw_unit_chk
  import stw_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_vld,
  input logic              ret_taken,
  input logic              ret_rfi,
  input logic              irq_vld,
  input logic              irq_hpmc,
  input logic              sw_we,
  input logic [WORD_W-1:0] sw_word,
  input logic              rc_we,
  input logic [WORD_W-1:0] status_word,
  input logic [CNT_W-1:0]  rc_value,
  input logic              rc_trap,
  input logic              ext_take
);

  AST_BRK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !irq_vld && !sw_we && !ret_rfi) |=> !status_word[POS_BRK_DIS]); // R2

  AST_TAKEN_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !irq_vld && !sw_we && !ret_rfi && !status_word[POS_NULLIFY])
      |=> status_word[POS_TAKEN] == $past(ret_taken)); // R3

  AST_NULLIFIED_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_vld && !irq_vld && !sw_we && status_word[POS_NULLIFY])
      |=> (!status_word[POS_NULLIFY] && !status_word[POS_TAKEN])); // R4

  AST_MC_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vld && !sw_we) |=> status_word[POS_MC_MASK] == $past(irq_hpmc)); // R5

  AST_SW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> status_word == $past(sw_word)); // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_we && ret_vld && !irq_vld && !sw_we && status_word[POS_RC_ENABLE] && !status_word[POS_NULLIFY])
      |=> rc_value == $past(rc_value) - CNT_W'(1)); // R8

  AST_NO_TRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[POS_RC_ENABLE] |-> !rc_trap); // R9

  AST_EXT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !status_word[POS_EXT_UNMASK] |-> !ext_take); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_vld && !irq_vld && !sw_we) |=> $stable(status_word)); // R12

endmodule

bind stw_unit stw_unit_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ret_vld     (ret_vld),
  .ret_taken   (ret_taken),
  .ret_rfi     (ret_rfi),
  .irq_vld     (irq_vld),
  .irq_hpmc    (irq_hpmc),
  .sw_we       (sw_we),
  .sw_word     (sw_word),
  .rc_we       (rc_we),
  .status_word (status_word),
  .rc_value    (rc_value),
  .rc_trap     (rc_trap),
  .ext_take    (ext_take)
);

// File: tb/test_stw_unit.sv
`timescale 1ns/1ps
module test_stw_unit;

  localparam real CLK_HALF = 4.0;
  localparam logic [31:0] RET_W = 32'h0000_0141;
  localparam logic [31:0] SW_W  = 32'h0000_0081;
  localparam int NVEC = 16;
  // {ret_vld, taken, nullnext, rfi, irq_vld, hpmc, sw_we, expected word[8:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {7'b0000000, 9'h000}, {7'b0000001, 9'h081}, {7'b1000000, 9'h001},
    {7'b1100000, 9'h081}, {7'b1010000, 9'h021}, {7'b1100000, 9'h001},
    {7'b0000110, 9'h101}, {7'b1100100, 9'h001}, {7'b1001000, 9'h141},
    {7'b1000000, 9'h101}, {7'b0000100, 9'h001}, {7'b1100111, 9'h081},
    {7'b1101000, 9'h141}, {7'b1010000, 9'h121}, {7'b1001000, 9'h101},
    {7'b0000000, 9'h101}
  };

  logic clk = 1'b0;
  logic rst_n, ret_vld, ret_taken, ret_nullnext, ret_rfi, irq_vld, irq_hpmc;
  logic sw_we, rc_we, ext_pend, pmu_pend;
  logic [31:0] sw_word, rc_wdata, status_word, rc_value;
  logic nullify_cur, rc_trap, ext_take, pmu_take;
  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #(CLK_HALF) clk = ~clk;

  stw_unit i_stw_unit (
    .clk(clk), .rst_n(rst_n), .ret_vld(ret_vld), .ret_taken(ret_taken),
    .ret_nullnext(ret_nullnext), .ret_rfi(ret_rfi), .ret_word(RET_W),
    .irq_vld(irq_vld), .irq_hpmc(irq_hpmc), .sw_we(sw_we), .sw_word(sw_word),
    .rc_we(rc_we), .rc_wdata(rc_wdata), .ext_pend(ext_pend), .pmu_pend(pmu_pend),
    .status_word(status_word), .nullify_cur(nullify_cur), .rc_value(rc_value),
    .rc_trap(rc_trap), .ext_take(ext_take), .pmu_take(pmu_take)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] c);
    {ret_vld, ret_taken, ret_nullnext, ret_rfi, irq_vld, irq_hpmc, sw_we} = c;
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
    drive(7'b0);
    rc_we = 1'b0;
  endtask

  function automatic string tag_of(input logic [6:0] c);
    if (c[0])      return "R7 sw override";
    else if (c[2]) return c[6] ? "R6 irq over retire" : "R5 irq mask bit";
    else if (c[3]) return "R2 rfi/break bit";
    else if (c[6]) return "R3 taken bit";
    else           return "R12 idle hold";
  endfunction

  initial begin
    #(CLK_HALF * 2 * 100000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; drive(7'b0); rc_we = 1'b0; rc_wdata = '0; sw_word = SW_W;
    ext_pend = 1'b1; pmu_pend = 1'b1;
    #20;
    chk("R1 word in reset", status_word, 32'h0);
    chk("R1 ext_take in reset", {31'b0, ext_take}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    chk("R1 word after reset", status_word, 32'h0);
    chk("R1 counter after reset", rc_value, 32'h0);
    chk("R1 trap after reset", {31'b0, rc_trap}, 32'h0);
    chk("R10 takes masked after reset", {30'b0, pmu_take, ext_take}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][15:9]);
      tick();
      chk(tag_of(VEC[i][15:9]), status_word, {23'b0, VEC[i][8:0]});
      chk("R4 nullify_cur", {31'b0, nullify_cur}, {31'b0, VEC[i][5]});
    end
    chk("R8 counter holds with enable clear", rc_value, 32'h0);

    // Counter: load with enable set
    sw_word = 32'h10; rc_wdata = 32'd5; rc_we = 1'b1; drive(7'b0000001); tick();
    chk("R11 counter load", rc_value, 32'd5);
    chk("R9 trap on odd count", {31'b0, rc_trap}, 32'h1);
    drive(7'b1000000); tick();
    chk("R8 decrement", rc_value, 32'd4);
    chk("R9 no trap on even", {31'b0, rc_trap}, 32'h0);
    drive(7'b1000000); tick(); drive(7'b1000000); tick();
    chk("R8 two more steps", rc_value, 32'd2);
    drive(7'b1100100); tick();
    chk("R6 irq blocks step", rc_value, 32'd2);
    drive(7'b1010000); tick();
    chk("R8 nullify-setter steps", rc_value, 32'd1);
    chk("R4 nullify armed", {31'b0, nullify_cur}, 32'h1);
    drive(7'b1100000); tick();
    chk("R4 nullified no step", rc_value, 32'd1);
    chk("R4 nullified word", status_word, 32'h10);
    rc_wdata = 32'd9; rc_we = 1'b1; drive(7'b1000000); tick();
    chk("R11 load beats step", rc_value, 32'd9);
    tick();
    chk("R12 idle counter", rc_value, 32'd9);
    chk("R12 idle word", status_word, 32'h10);
    sw_word = 32'h0; drive(7'b0000001); tick();
    drive(7'b1000000); tick();
    chk("R8 disabled holds", rc_value, 32'd9);
    chk("R9 no trap when disabled", {31'b0, rc_trap}, 32'h0);

    // Interrupt gating
    sw_word = 32'h01; drive(7'b0000001); tick();
    chk("R10 ext unmasked", {30'b0, pmu_take, ext_take}, 32'h1);
    sw_word = 32'h08; drive(7'b0000001); tick();
    chk("R10 pmu unmasked", {30'b0, pmu_take, ext_take}, 32'h2);
    ext_pend = 1'b0; pmu_pend = 1'b0; #1;
    chk("R10 nothing pending", {30'b0, pmu_take, ext_take}, 32'h0);

    // Asynchronous reset mid-run
    @(negedge clk); #1 rst_n = 1'b0; #1;
    chk("R1 async clear word", status_word, 32'h0);
    chk("R1 async clear counter", rc_value, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;

    // Wrap through zero
    sw_word = 32'h10; drive(7'b0000001); tick();
    drive(7'b1000000); tick();
    chk("R8 wrap", rc_value, 32'hFFFF_FFFF);
    chk("R9 trap after wrap", {31'b0, rc_trap}, 32'h1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule